// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a packet command whose data comes back to the host by programmed I/O. The host first writes a byte-count limit, then issues the packet command code. It then writes a 12-byte command descriptor as six 16-bit words. When the descriptor is a READ(10), the block reads the requested 2048-byte blocks from a word-addressed media source and hands them to the host one word per data-register read.

The transfer is cut into bursts. The host's limit sets the burst size: an odd limit loses its low bit, and the final burst carries whatever remains. Before each burst the block raises its interrupt, presents DRQ with DRDY, and shows the burst's byte count in the two count registers. After the last word it raises one more interrupt with DRQ clear. A read of the status register drops the interrupt.

Host register offsets: 0 data, 1 feature, 4 count low byte, 5 count high byte, 7 command on write and status on read. Status bits: 7 BSY, 6 DRDY, 5 DF, 3 DRQ, 0 ERR. All other status bits read as zero.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register reads 0x40 (DRDY only) and the interrupt is low.
- R2: Writing 0xA0 to offset 7 while idle, with feature bit 0 clear, opens the packet phase with status 0x48 (DRQ, DRDY). Any other command code is ignored: status stays 0x40 and no interrupt occurs.
- R3: The packet is six data writes; word i carries descriptor byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Opcode 0x28 (byte 0) is a READ(10). Its LBA is big-endian in bytes 2..5 and its block count is big-endian in bytes 7..8. Data word k of the transfer is media word LBA*1024+k.
- R4: Burst size in bytes is the smaller of the remaining byte count and the limit from offsets 4 (low) and 5 (high) with bit 0 cleared. A limit of 0 or 1 gives 2-byte bursts.
- R5: Before every burst the interrupt rises, status reads 0x48, and offsets 4/5 read the burst's byte count.
- R6: After the last word of the last burst the interrupt rises and status reads 0x40.
- R7: A status read lowers a pending interrupt.
- R8: A descriptor whose opcode is not 0x28 ends the command after the sixth word with an interrupt and status 0x41 (DRDY, ERR), with no data phase.
- R9: Issuing 0xA0 with feature bit 0 set (DMA requested) ends the command at once with an interrupt and status 0x41, and no packet phase.
- R10: A READ(10) with a block count of zero completes after the packet with an interrupt and status 0x40.
- R11: BSY and DRQ are never set together. BSY shows while each burst is being prepared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered one cycle after the strobe |
| irq | output | 1 | Interrupt request to host |
| media_addr | output | 42 | Word address into the media source |
| media_rdata | input | 16 | Media word at media_addr, same cycle |

## Verification
A corrupted burst remainder or word pointer appears at the data port within the same burst. It shows up either as a wrong media word or as an interrupt arriving after the wrong number of reads. A wrong burst size appears in the count registers before the first word of that burst is moved. A stuck phase state appears as a status value other than 0x48 at the next interrupt, or as a missing final interrupt. The bench compares every returned word against its own media model and counts the bursts it sees against the split it derives from the limit.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_FEAT  = 3'd1;
  localparam logic [2:0] OFS_CNTLO = 3'd4;
  localparam logic [2:0] OFS_CNTHI = 3'd5;
  localparam logic [2:0] OFS_CMDST = 3'd7;

  localparam logic [7:0] CMD_PKT   = 8'hA0;
  localparam logic [7:0] OP_RD10   = 8'h28;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PKT  = 2'd1,
    PH_PREP = 2'd2,
    PH_XFER = 2'd3
  } phase_t;
endpackage

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture #(
  parameter int PKT_WORDS = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        last,
  output logic [7:0]  opcode,
  output logic [31:0] lba,
  output logic [15:0] nblk
);
  localparam int IW = $clog2(PKT_WORDS);

  logic [IW-1:0] idx_q;
  logic [15:0]   words_q [PKT_WORDS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (wr_en) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) words_q[idx_q] <= wr_data;
  end

  assign last   = wr_en && (idx_q == IW'(PKT_WORDS - 1));
  // fields use words 0..4 only, all stored before the final write lands
  assign opcode = words_q[0][7:0];
  assign lba    = {words_q[1][7:0], words_q[1][15:8], words_q[2][7:0], words_q[2][15:8]};
  assign nblk   = {words_q[3][15:8], words_q[4][7:0]};
endmodule

// File: rtl/atapi_burst_size.sv
module atapi_burst_size #(
  parameter int REM_W = 26
) (
  input  logic [15:0]      limit,
  input  logic [REM_W-1:0] rem_words,
  output logic [14:0]      burst_words,
  output logic [15:0]      burst_bytes
);
  logic [14:0] eff_words;

  always_comb begin
    eff_words = (limit[15:1] == 15'd0) ? 15'd1 : limit[15:1];
    if (rem_words < REM_W'(eff_words)) burst_words = rem_words[14:0];
    else                               burst_words = eff_words;
    burst_bytes = {burst_words, 1'b0};
  end
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int BLOCK_BYTES = 2048,
  parameter int PKT_WORDS   = 6,
  parameter int LBA_W       = 32,
  parameter int CNT_W       = 16,
  localparam int WPB_W      = $clog2(BLOCK_BYTES / 2),
  localparam int REM_W      = CNT_W + WPB_W,
  localparam int MEDIA_AW   = LBA_W + WPB_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [2:0]          host_addr,
  input  logic [15:0]         host_wdata,
  output logic [15:0]         host_rdata,
  output logic                irq,
  output logic [MEDIA_AW-1:0] media_addr,
  input  logic [15:0]         media_rdata
);
  phase_t              phase_q;
  logic                bsy_q, drq_q, err_q, irq_q;
  logic [7:0]          feat_q;
  logic [15:0]         bcl_q;
  logic [REM_W-1:0]    rem_q;
  logic [14:0]         left_q;
  logic [MEDIA_AW-1:0] maddr_q;
  logic [15:0]         rdata_q;

  logic        pkt_wr, pkt_last;
  logic [7:0]  pkt_op;
  logic [31:0] pkt_lba;
  logic [15:0] pkt_nblk;
  logic [14:0] bw;
  logic [15:0] bb;
  logic [7:0]  status;
  logic        data_rd;

  assign status  = {bsy_q, 1'b1, 1'b0, 1'b0, drq_q, 2'b00, err_q};
  assign pkt_wr  = host_wr && (host_addr == OFS_DATA) && (phase_q == PH_PKT);
  assign data_rd = host_rd && (host_addr == OFS_DATA) && (phase_q == PH_XFER);

  atapi_pkt_capture #(.PKT_WORDS(PKT_WORDS)) cap_i (
    .clk(clk), .rst(rst), .clr(phase_q == PH_IDLE),
    .wr_en(pkt_wr), .wr_data(host_wdata),
    .last(pkt_last), .opcode(pkt_op), .lba(pkt_lba), .nblk(pkt_nblk)
  );

  atapi_burst_size #(.REM_W(REM_W)) bsz_i (
    .limit(bcl_q), .rem_words(rem_q), .burst_words(bw), .burst_bytes(bb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bsy_q   <= 1'b0;
      drq_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      feat_q  <= '0;
      bcl_q   <= '0;
      rem_q   <= '0;
      left_q  <= '0;
      maddr_q <= '0;
      rdata_q <= '0;
    end else begin
      if (host_rd) begin
        case (host_addr)
          OFS_DATA:  rdata_q <= (phase_q == PH_XFER) ? media_rdata : 16'h0;
          OFS_FEAT:  rdata_q <= {8'h0, feat_q};
          OFS_CNTLO: rdata_q <= {8'h0, bcl_q[7:0]};
          OFS_CNTHI: rdata_q <= {8'h0, bcl_q[15:8]};
          OFS_CMDST: rdata_q <= {8'h0, status};
          default:   rdata_q <= 16'h0;
        endcase
        if (host_addr == OFS_CMDST) irq_q <= 1'b0;
      end
      case (phase_q)
        PH_IDLE: begin
          if (host_wr) begin
            case (host_addr)
              OFS_FEAT:  feat_q      <= host_wdata[7:0];
              OFS_CNTLO: bcl_q[7:0]  <= host_wdata[7:0];
              OFS_CNTHI: bcl_q[15:8] <= host_wdata[7:0];
              OFS_CMDST: begin
                if (host_wdata[7:0] == CMD_PKT) begin
                  if (feat_q[0]) begin
                    err_q <= 1'b1;
                    irq_q <= 1'b1;
                  end else begin
                    err_q   <= 1'b0;
                    irq_q   <= 1'b0;
                    drq_q   <= 1'b1;
                    phase_q <= PH_PKT;
                  end
                end
              end
              default: ;
            endcase
          end
        end
        PH_PKT: begin
          if (pkt_last) begin
            drq_q <= 1'b0;
            if (pkt_op != OP_RD10) begin
              err_q   <= 1'b1;
              irq_q   <= 1'b1;
              phase_q <= PH_IDLE;
            end else if (pkt_nblk == 16'h0) begin
              irq_q   <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              bsy_q   <= 1'b1;
              rem_q   <= {pkt_nblk, {WPB_W{1'b0}}};
              maddr_q <= {pkt_lba, {WPB_W{1'b0}}};
              phase_q <= PH_PREP;
            end
          end
        end
        PH_PREP: begin
          left_q  <= bw;
          bcl_q   <= bb;
          rem_q   <= rem_q - REM_W'(bw);
          bsy_q   <= 1'b0;
          drq_q   <= 1'b1;
          irq_q   <= 1'b1;
          phase_q <= PH_XFER;
        end
        PH_XFER: begin
          if (data_rd) begin
            maddr_q <= maddr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == 15'd1) begin
              drq_q <= 1'b0;
              if (rem_q == '0) begin
                irq_q   <= 1'b1;
                phase_q <= PH_IDLE;
              end else begin
                bsy_q   <= 1'b1;
                phase_q <= PH_PREP;
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = irq_q;
  assign media_addr = maddr_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
  import atapi_seq_pkg::*;
#(
  parameter int MEDIA_AW = 42
) (
  input logic                clk,
  input logic                rst,
  input logic                host_rd,
  input logic                host_wr,
  input logic [2:0]          host_addr,
  input logic                irq,
  input logic                bsy_q,
  input logic                drq_q,
  input phase_t              phase_q,
  input logic [15:0]         bcl_q,
  input logic [MEDIA_AW-1:0] media_addr
);
  a_r11_bsy_drq_excl: assert property (@(posedge clk) disable iff (rst)
    !(bsy_q && drq_q));

  a_r7_status_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFS_CMDST && phase_q == PH_IDLE && !host_wr) |=> !irq);

  a_r4_burst_even_nonzero: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_XFER) |-> (bcl_q[0] == 1'b0 && bcl_q != 16'h0));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFS_DATA && phase_q == PH_XFER)
      |=> media_addr == $past(media_addr) + 1'b1);

  a_r6_irq_not_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !bsy_q);

  a_r2_drq_phase: assert property (@(posedge clk) disable iff (rst)
    drq_q |-> (phase_q == PH_PKT || phase_q == PH_XFER));
endmodule

bind atapi_pio_seq atapi_pio_seq_chk #(.MEDIA_AW(MEDIA_AW)) chk_i (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .irq(irq), .bsy_q(bsy_q), .drq_q(drq_q),
  .phase_q(phase_q), .bcl_q(bcl_q), .media_addr(media_addr)
);

// File: tb/atapi_pio_seq_tb_top.sv
module atapi_pio_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        irq;
  logic [41:0] media_addr;
  logic [15:0] media_rdata;

  int ntests = 0, nfail = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] mword(logic [41:0] a);
    return a[15:0] ^ {a[25:16], 6'h2B} ^ 16'h5A3C;
  endfunction

  assign media_rdata = mword(media_addr);

  atapi_pio_seq dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .media_addr(media_addr), .media_rdata(media_rdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (irq) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] n);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {n[15:8], 8'h00});
    wr(3'd0, {8'h00, n[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  task automatic start_cmd(input logic [15:0] limit, input logic [7:0] feat);
    wr(3'd4, {8'h0, limit[7:0]});
    wr(3'd5, {8'h0, limit[15:8]});
    wr(3'd1, {8'h0, feat});
    wr(3'd7, 16'h00A0);
  endtask

  task automatic run_read(input logic [15:0] limit, input logic [31:0] lba, input logic [15:0] n);
    logic [15:0] d, lo, hi;
    longint rem, eff, exp, widx;
    int e_stat = 0, e_cnt = 0, e_data = 0, e_irq = 0, bursts = 0, exp_bursts = 0;
    bit seen;
    start_cmd(limit, 8'h00);
    rd(3'd7, d);
    check(d[7:0] == 8'h48, "R2 packet phase status", d[7:0], 8'h48);
    send_pkt(8'h28, lba, n);
    rem  = longint'(n) * 2048;
    eff  = (limit & 16'hFFFE) == 0 ? 2 : longint'(limit & 16'hFFFE);
    widx = 0;
    exp_bursts = int'((rem + eff - 1) / eff);
    while (rem > 0) begin
      wait_irq(seen);
      if (!seen) e_irq++;
      rd(3'd7, d);
      if (d[7:0] != 8'h48) e_stat++;
      if (irq) e_irq++;
      exp = (rem < eff) ? rem : eff;
      rd(3'd4, lo);
      rd(3'd5, hi);
      if ({hi[7:0], lo[7:0]} != 16'(exp)) e_cnt++;
      for (longint k = 0; k < exp / 2; k++) begin
        rd(3'd0, d);
        if (d != mword(42'({lba, 10'd0}) + 42'(widx))) e_data++;
        widx++;
      end
      rem -= exp;
      bursts++;
      if (bursts > 5000) break;
    end
    check(e_irq == 0, "R5/R7 burst interrupt and clear", e_irq, 0);
    check(e_stat == 0, "R5 burst status 0x48", e_stat, 0);
    check(e_cnt == 0, "R4 burst byte count", e_cnt, 0);
    check(bursts == exp_bursts, "R4 number of bursts", bursts, exp_bursts);
    check(e_data == 0, "R3 data words match media", e_data, 0);
    wait_irq(seen);
    check(seen, "R6 final interrupt", seen, 1);
    rd(3'd7, d);
    check(d[7:0] == 8'h40, "R6 final status", d[7:0], 8'h40);
    check(!irq, "R7 interrupt cleared by status read", irq, 0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check(!irq, "R1 irq low after reset", irq, 0);
    rd(3'd7, d);
    check(d[7:0] == 8'h40, "R1 reset status", d[7:0], 8'h40);
  endtask

  task automatic t_ignored_cmd();
    logic [15:0] d;
    wr(3'd7, 16'h00EC);
    repeat (3) @(negedge clk);
    check(!irq, "R2 unknown command raises no irq", irq, 0);
    rd(3'd7, d);
    check(d[7:0] == 8'h40, "R2 unknown command ignored", d[7:0], 8'h40);
  endtask

  task automatic t_bad_opcode();
    logic [15:0] d;
    bit seen;
    start_cmd(16'd4096, 8'h00);
    send_pkt(8'h12, 32'd0, 16'd1);
    wait_irq(seen);
    check(seen, "R8 irq on unsupported opcode", seen, 1);
    rd(3'd7, d);
    check(d[7:0] == 8'h41, "R8 error status", d[7:0], 8'h41);
  endtask

  task automatic t_dma_req();
    logic [15:0] d;
    bit seen;
    start_cmd(16'd4096, 8'h01);
    wait_irq(seen);
    check(seen, "R9 irq on DMA request", seen, 1);
    rd(3'd7, d);
    check(d[7:0] == 8'h41, "R9 DMA request rejected", d[7:0], 8'h41);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_zero_count();
    logic [15:0] d;
    bit seen;
    start_cmd(16'd4096, 8'h00);
    send_pkt(8'h28, 32'd7, 16'd0);
    wait_irq(seen);
    check(seen, "R10 irq on zero count", seen, 1);
    rd(3'd7, d);
    check(d[7:0] == 8'h40, "R10 zero-count completion", d[7:0], 8'h40);
  endtask

  task automatic t_busy_between();
    logic [15:0] d;
    bit seen;
    int bad = 0;
    start_cmd(16'd1024, 8'h00);
    send_pkt(8'h28, 32'd1, 16'd1);
    // sample status during burst preparation: not both BSY and DRQ
    for (int b = 0; b < 2; b++) begin
      wait_irq(seen);
      rd(3'd7, d);
      if (d[7] && d[3]) bad++;
      for (int k = 0; k < 512; k++) rd(3'd0, d);
      rd(3'd7, d);
      if (d[7] && d[3]) bad++;
    end
    wait_irq(seen);
    rd(3'd7, d);
    check(bad == 0, "R11 BSY and DRQ exclusive", bad, 0);
    check(d[7:0] == 8'h40, "R11 completion after split read", d[7:0], 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ignored_cmd();
    run_read(16'd5120, 32'd3, 16'd1);
    run_read(16'd5121, 32'h0001_0002, 16'd4);
    run_read(16'd1001, 32'd9, 16'd1);
    run_read(16'd0, 32'd5, 16'd1);
    t_bad_opcode();
    t_dma_req();
    t_zero_count();
    t_busy_between();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule